// File: doc/BRIEF.md
# Minimal 16-bit Single-Cycle Processor Core

This block is a small 16-bit processor core that retires one instruction on every clock edge. It holds sixteen 16-bit registers. Register 14 is the program counter and is also an ordinary register. Any instruction that writes register 14 therefore redirects fetch, and reading register 14 returns the address of the instruction being executed. Instructions arrive one 16-bit word at a time over a byte-addressed code port. Data traffic uses a separate port made of an address, write data, read data and a write strobe. Both memories sit outside the block and are expected to answer combinationally within the same cycle.

The instruction set is deliberately small: set-immediate, load, store, add, compare, and branch-if-equal. Compare leaves a single equality flag behind, and a later branch-if-equal consumes it. The block is meant for bring-up of a memory subsystem and for short self-test loops. A reset synchroniser inside the block makes reset assert asynchronously and release on the clock.

Top module: `tiny16_core`

## Requirements
- R1: While `rst_n_i` is low, `code_addr_o` is 0x0000, `dmem_we_o` is low, all registers are 0 and the equality flag is clear. After release, the core holds the code address at 0x0000 for two further rising edges and executes its first instruction on the third.
- R2: An instruction that does not write register 14 advances `code_addr_o` by 2 at the clock edge.
- R3: The opcode is in bits 15:12: 0x0 no-op, 0x1 load, 0x2 store, 0x3 add, 0xC compare, 0xD branch-if-equal, 0xE set-immediate. Field A is bits 11:8, field B is bits 7:4, field C is bits 3:0 and the immediate is bits 7:0.
- R4: Set-immediate writes the immediate, zero-extended, into the register named by field A.
- R5: Any register write whose destination is register 14 makes the written value the next code address. This covers set-immediate, add, load and a taken branch. Register 14 read as an operand yields the current instruction's address.
- R6: In the cycle a store is presented, `dmem_wdata_o` carries the register named by field A, `dmem_addr_o` carries the register named by field B, and `dmem_we_o` is high.
- R7: Load drives the register named by field B onto `dmem_addr_o` with `dmem_we_o` low, and writes `dmem_rdata_i` into the register named by field A at the clock edge.
- R8: Add writes the sum of the registers named by fields B and C, modulo 2^16, into the register named by field A.
- R9: Compare sets the flag to 1 when the registers named by fields B and C are equal, and to 0 otherwise. No other instruction changes the flag.
- R10: Branch-if-equal with the flag set adds the sign-extended immediate to the register named by field A. With field A equal to 14, the next code address is the branch's own address plus that offset. With the flag clear, nothing is written and the code address advances by 2.
- R11: `dmem_we_o` is low for every instruction other than store.
- R12: Opcodes outside the listed set write no register, leave the flag unchanged, keep the strobe low and advance the code address by 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| code_addr_o | output | 16 | Byte address of the instruction to fetch (register 14) |
| code_data_i | input | 16 | Instruction word at `code_addr_o` |
| dmem_addr_o | output | 16 | Data address (register named by field B) |
| dmem_wdata_o | output | 16 | Store data (register named by field A) |
| dmem_rdata_i | input | 16 | Read data at `dmem_addr_o` |
| dmem_we_o | output | 1 | Data write strobe, high only for store |

## Verification
The code address is the program counter itself, so a wrong flag or a wrong jump target shows on `code_addr_o` at the very next edge. A corrupted register stays hidden until a store exposes it on `dmem_wdata_o` or `dmem_addr_o`. A wrong add or load result is only seen when a later store or a jump through register 14 uses it. The test program therefore routes every computed value to a store or a redirect within a few cycles of producing it. A second program run after a mid-run reset checks, by storing them, that registers came back cleared.

// File: rtl/tiny16_pkg.sv
package tiny16_pkg;

  localparam int INSN_W  = 16;
  localparam int FIELD_W = 4;
  localparam int IMM_W   = 8;

  localparam logic [FIELD_W-1:0] OPC_NOP   = 4'h0;
  localparam logic [FIELD_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [FIELD_W-1:0] OPC_STORE = 4'h2;
  localparam logic [FIELD_W-1:0] OPC_ADD   = 4'h3;
  localparam logic [FIELD_W-1:0] OPC_CMP   = 4'hC;
  localparam logic [FIELD_W-1:0] OPC_BEQ   = 4'hD;
  localparam logic [FIELD_W-1:0] OPC_SET   = 4'hE;

  typedef enum logic [1:0] {
    WB_IMM = 2'd0,
    WB_MEM = 2'd1,
    WB_SUM = 2'd2
  } wb_sel_e;

  typedef struct packed {
    logic [FIELD_W-1:0] fa;
    logic [FIELD_W-1:0] fb;
    logic [FIELD_W-1:0] fc;
    logic [IMM_W-1:0]   imm;
    logic               wr_req;
    logic               is_beq;
    logic               mem_we;
    logic               cmp_en;
    logic               use_off;
    wb_sel_e            wb_sel;
  } dec_t;

endpackage

// File: rtl/tiny16_rst_sync.sv
module tiny16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/tiny16_decode.sv
module tiny16_decode
  import tiny16_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output dec_t              dec_o
);

  logic [FIELD_W-1:0] opc;

  assign opc = insn_i[INSN_W-1 -: FIELD_W];

  always_comb begin
    dec_o         = '0;
    dec_o.fa      = insn_i[11:8];
    dec_o.fb      = insn_i[7:4];
    dec_o.fc      = insn_i[3:0];
    dec_o.imm     = insn_i[IMM_W-1:0];
    dec_o.wb_sel  = WB_SUM;
    case (opc)
      OPC_SET: begin
        dec_o.wr_req = 1'b1;
        dec_o.wb_sel = WB_IMM;
      end
      OPC_LOAD: begin
        dec_o.wr_req = 1'b1;
        dec_o.wb_sel = WB_MEM;
      end
      OPC_STORE: begin
        dec_o.mem_we = 1'b1;
      end
      OPC_ADD: begin
        dec_o.wr_req = 1'b1;
        dec_o.wb_sel = WB_SUM;
      end
      OPC_CMP: begin
        dec_o.cmp_en = 1'b1;
      end
      OPC_BEQ: begin
        dec_o.wr_req  = 1'b1;
        dec_o.is_beq  = 1'b1;
        dec_o.use_off = 1'b1;
        dec_o.wb_sel  = WB_SUM;
      end
      default: begin
        dec_o.wr_req = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/tiny16_regfile.sv
module tiny16_regfile #(
  parameter  int XLEN   = 16,
  parameter  int NREGS  = 16,
  parameter  int PC_IDX = 14,
  localparam int IDX_W  = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [XLEN-1:0]  wr_data_i,
  input  logic [XLEN-1:0]  pc_seq_i,
  input  logic [IDX_W-1:0] fa_idx_i,
  input  logic [IDX_W-1:0] fb_idx_i,
  input  logic [IDX_W-1:0] fc_idx_i,
  output logic [XLEN-1:0]  fa_val_o,
  output logic [XLEN-1:0]  fb_val_o,
  output logic [XLEN-1:0]  fc_val_o,
  output logic [XLEN-1:0]  pc_o
);

  logic [NREGS-1:0][XLEN-1:0] rf_q;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic            hit;
    logic            r_en;
    logic [XLEN-1:0] r_d;
    logic [XLEN-1:0] r_q;

    assign hit = wr_en_i && (wr_idx_i == IDX_W'(i));

    if (i == PC_IDX) begin : g_pc
      always_comb begin
        r_en = 1'b1;
        r_d  = hit ? wr_data_i : pc_seq_i;
      end
    end else begin : g_gpr
      always_comb begin
        r_en = hit;
        r_d  = wr_data_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
        r_q <= '0;
      end else if (r_en) begin
        r_q <= r_d;
      end
    end

    assign rf_q[i] = r_q;
  end

  assign fa_val_o = rf_q[fa_idx_i];
  assign fb_val_o = rf_q[fb_idx_i];
  assign fc_val_o = rf_q[fc_idx_i];
  assign pc_o     = rf_q[PC_IDX];

endmodule

// File: rtl/tiny16_alu.sv
module tiny16_alu #(
  parameter int XLEN = 16
) (
  input  logic [XLEN-1:0] op_a_i,
  input  logic [XLEN-1:0] op_b_i,
  output logic [XLEN-1:0] sum_o,
  output logic            eq_o
);

  assign sum_o = op_a_i + op_b_i;
  assign eq_o  = (op_a_i == op_b_i);

endmodule

// File: rtl/tiny16_core.sv
module tiny16_core
  import tiny16_pkg::*;
#(
  parameter int XLEN       = 16,
  parameter int PC_IDX     = 14,
  parameter int RST_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  output logic [XLEN-1:0] code_addr_o,
  input  logic [XLEN-1:0] code_data_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  input  logic [XLEN-1:0] dmem_rdata_i,
  output logic            dmem_we_o
);

  localparam int NREGS   = 2 ** FIELD_W;
  localparam int PC_STEP = INSN_W / 8;
  localparam int EXT_W   = XLEN - IMM_W;

  logic            rst_core_n;
  dec_t            dec;
  logic [XLEN-1:0] fa_val;
  logic [XLEN-1:0] fb_val;
  logic [XLEN-1:0] fc_val;
  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] pc_seq;
  logic [XLEN-1:0] imm_zx;
  logic [XLEN-1:0] imm_sx;
  logic [XLEN-1:0] alu_a;
  logic [XLEN-1:0] alu_b;
  logic [XLEN-1:0] alu_sum;
  logic            alu_eq;
  logic [XLEN-1:0] wb_data;
  logic            wb_en;
  logic            flag_q;
  logic            flag_d;
  logic            flag_en;

  tiny16_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_core_n)
  );

  tiny16_decode u_decode (
    .insn_i (code_data_i[INSN_W-1:0]),
    .dec_o  (dec)
  );

  tiny16_regfile #(
    .XLEN   (XLEN),
    .NREGS  (NREGS),
    .PC_IDX (PC_IDX)
  ) u_regfile (
    .clk_i     (clk_i),
    .rst_n_i   (rst_core_n),
    .wr_en_i   (wb_en),
    .wr_idx_i  (dec.fa),
    .wr_data_i (wb_data),
    .pc_seq_i  (pc_seq),
    .fa_idx_i  (dec.fa),
    .fb_idx_i  (dec.fb),
    .fc_idx_i  (dec.fc),
    .fa_val_o  (fa_val),
    .fb_val_o  (fb_val),
    .fc_val_o  (fc_val),
    .pc_o      (pc)
  );

  // Immediate forms: zero-extended for set, sign-extended byte offset for branch.
  assign imm_zx = {{EXT_W{1'b0}}, dec.imm};
  assign imm_sx = {{EXT_W{dec.imm[IMM_W-1]}}, dec.imm};
  assign pc_seq = pc + XLEN'(PC_STEP);

  // One adder serves add, compare and the branch target.
  always_comb begin
    if (dec.use_off) begin
      alu_a = fa_val;
      alu_b = imm_sx;
    end else begin
      alu_a = fb_val;
      alu_b = fc_val;
    end
  end

  tiny16_alu #(
    .XLEN (XLEN)
  ) u_alu (
    .op_a_i (alu_a),
    .op_b_i (alu_b),
    .sum_o  (alu_sum),
    .eq_o   (alu_eq)
  );

  always_comb begin
    case (dec.wb_sel)
      WB_IMM:  wb_data = imm_zx;
      WB_MEM:  wb_data = dmem_rdata_i;
      default: wb_data = alu_sum;
    endcase
    wb_en = dec.wr_req && (!dec.is_beq || flag_q);
  end

  always_comb begin
    flag_en = dec.cmp_en;
    flag_d  = alu_eq;
  end

  always_ff @(posedge clk_i or negedge rst_core_n) begin
    if (!rst_core_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign code_addr_o  = pc;
  assign dmem_addr_o  = fb_val;
  assign dmem_wdata_o = fa_val;
  assign dmem_we_o    = dec.mem_we && rst_core_n;

endmodule

// File: rtl/tiny16_core_chk.sv
module tiny16_core_chk #(
  parameter int XLEN = 16
) (
  input logic            clk_i,
  input logic            rst_n_i,
  input logic            rst_core_n,
  input logic [XLEN-1:0] code_addr_o,
  input logic [XLEN-1:0] code_data_i,
  input logic            dmem_we_o,
  input logic            flag_q
);

  logic [3:0] opc;
  logic [3:0] fa;
  logic [7:0] imm;
  logic       writes_pc;
  logic       beq_pc;

  assign opc       = code_data_i[15:12];
  assign fa        = code_data_i[11:8];
  assign imm       = code_data_i[7:0];
  assign beq_pc    = (opc == 4'hD) && (fa == 4'hE);
  assign writes_pc = (fa == 4'hE) &&
                     (opc == 4'hE || opc == 4'h1 || opc == 4'h3 || opc == 4'hD);

  // R1: held in reset at the code address origin with no write
  a_r1_reset_origin: assert property (@(posedge clk_i)
    !rst_n_i |-> (code_addr_o == '0 && !dmem_we_o));

  // R2 / R12: sequential advance when register 14 is not written
  a_r2_step_two: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    !writes_pc |=> code_addr_o == $past(code_addr_o) + XLEN'(2));

  // R5: set-immediate into register 14 is a jump
  a_r5_set_jump: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    (opc == 4'hE && fa == 4'hE) |=> code_addr_o == XLEN'($past(imm)));

  // R6: store raises the strobe
  a_r6_store_strobe: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    (opc == 4'h2) |-> dmem_we_o);

  // R11: strobe only for store
  a_r11_strobe_only_store: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    dmem_we_o |-> (opc == 4'h2));

  // R10: taken branch adds the signed offset to its own address
  a_r10_beq_taken: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    (beq_pc && flag_q) |=>
      code_addr_o == $past(code_addr_o) + {{(XLEN-8){$past(imm[7])}}, $past(imm)});

  // R10: untaken branch falls through
  a_r10_beq_fall: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    (beq_pc && !flag_q) |=> code_addr_o == $past(code_addr_o) + XLEN'(2));

  // R9: only compare moves the flag
  a_r9_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    (opc != 4'hC) |=> $stable(flag_q));

endmodule

bind tiny16_core tiny16_core_chk #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_n_i     (rst_n_i),
  .rst_core_n  (rst_core_n),
  .code_addr_o (code_addr_o),
  .code_data_i (code_data_i),
  .dmem_we_o   (dmem_we_o),
  .flag_q      (flag_q)
);

// File: tb/tiny16_core_tb.sv
`timescale 1ns/1ps
module tiny16_core_tb;

  typedef struct packed {
    logic [15:0] pc;
    logic        chk_a;
    logic        chk_d;
    logic        we;
    logic [15:0] da;
    logic [15:0] wd;
  } vec_t;

  localparam int NVEC = 21;

  // Program 1 trace, one entry per executed instruction.
  localparam vec_t VEC [NVEC] = '{
    '{16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},  // NOP
    '{16'h0002, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},  // SET r0,42
    '{16'h0004, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},  // SET r1,0x25
    '{16'h0006, 1'b1, 1'b1, 1'b1, 16'h0025, 16'h002A},  // STORE r0,[r1]
    '{16'h0008, 1'b1, 1'b0, 1'b0, 16'h0025, 16'h0000},  // LOAD r2,[r1]
    '{16'h000A, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},  // ADD r3,r2,r2
    '{16'h000C, 1'b1, 1'b1, 1'b1, 16'h0025, 16'h0054},  // STORE r3,[r1]
    '{16'h000E, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},  // CMP r2,r0 equal
    '{16'h0010, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},  // BEQ +4 taken
    '{16'h0014, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},  // CMP r3,r0 differ
    '{16'h0016, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},  // BEQ +8 not taken
    '{16'h0018, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},  // unlisted 0x9E55
    '{16'h001A, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},  // SET r4,0x40
    '{16'h001C, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},  // ADD r5,r4,r3
    '{16'h001E, 1'b1, 1'b1, 1'b1, 16'h0094, 16'h002A},  // STORE r0,[r5]
    '{16'h0020, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},  // CMP r0,r2 equal
    '{16'h0022, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},  // NOP, flag held
    '{16'h0024, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},  // BEQ +4 taken
    '{16'h0028, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},  // SET r14,0
    '{16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},  // wrapped to start
    '{16'h0002, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000}
  };

  logic        clk;
  logic        rst_n;
  logic [15:0] code_addr;
  logic [15:0] code_data;
  logic [15:0] dmem_addr;
  logic [15:0] dmem_wdata;
  logic [15:0] dmem_rdata;
  logic        dmem_we;

  logic [15:0] rom  [32];
  logic [15:0] dmem [64];

  int n_chk;
  int n_fail;
  bit done;

  tiny16_core u_dut (
    .clk_i        (clk),
    .rst_n_i      (rst_n),
    .code_addr_o  (code_addr),
    .code_data_i  (code_data),
    .dmem_addr_o  (dmem_addr),
    .dmem_wdata_o (dmem_wdata),
    .dmem_rdata_i (dmem_rdata),
    .dmem_we_o    (dmem_we)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign code_data  = rom[code_addr[5:1]];
  assign dmem_rdata = dmem[dmem_addr[5:0]];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;
  end

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load_prog1();
    for (int i = 0; i < 32; i++) rom[i] = 16'h0000;
    rom[0]  = 16'h0000; rom[1]  = 16'hE02A; rom[2]  = 16'hE125;
    rom[3]  = 16'h2010; rom[4]  = 16'h1210; rom[5]  = 16'h3322;
    rom[6]  = 16'h2310; rom[7]  = 16'hC020; rom[8]  = 16'hDE04;
    rom[9]  = 16'h0000; rom[10] = 16'hC030; rom[11] = 16'hDE08;
    rom[12] = 16'h9E55; rom[13] = 16'hE440; rom[14] = 16'h3543;
    rom[15] = 16'h2050; rom[16] = 16'hC002; rom[17] = 16'h0000;
    rom[18] = 16'hDE04; rom[19] = 16'h0000; rom[20] = 16'hEE00;
  endtask

  task automatic load_prog2();
    for (int i = 0; i < 32; i++) rom[i] = 16'h0000;
    rom[0] = 16'h2650;  // STORE r6,[r5] exposes cleared registers
    rom[1] = 16'hE108;  // SET r1,8
    rom[2] = 16'h3E1E;  // ADD r14,r1,r14 -> 4+8
    rom[6] = 16'hEE00;  // SET r14,0
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk  = 0;
    n_fail = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    for (int i = 0; i < 64; i++) dmem[i] = 16'h0000;
    load_prog1();

    repeat (3) @(negedge clk);
    chk("R1", "code_addr in reset", code_addr, 16'h0000);
    chk("R1", "strobe in reset", {15'b0, dmem_we}, 16'h0000);

    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "code_addr held after release", code_addr, 16'h0000);

    // Table walk: R2 R4 R5 R6 R7 R8 R9 R10 R11 R12
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      chk("R2/R10/R12", $sformatf("vec %0d code_addr", v), code_addr, VEC[v].pc);
      chk("R6/R11", $sformatf("vec %0d strobe", v), {15'b0, dmem_we}, {15'b0, VEC[v].we});
      if (VEC[v].chk_a)
        chk("R6/R7", $sformatf("vec %0d data addr", v), dmem_addr, VEC[v].da);
      if (VEC[v].chk_d)
        chk("R6/R8", $sformatf("vec %0d write data", v), dmem_wdata, VEC[v].wd);
    end

    // R7 R8: loaded 42 doubled and stored back at 0x25
    chk("R7/R8", "mem[0x25]", dmem[6'h25], 16'h0054);
    // R4 R8: store through computed address 0x94 lands at index 0x14
    chk("R4/R8", "mem[0x14]", dmem[6'h14], 16'h002A);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "code_addr on async reset", code_addr, 16'h0000);
    chk("R1", "strobe on async reset", {15'b0, dmem_we}, 16'h0000);
    load_prog2();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "hold after second release", code_addr, 16'h0000);
    @(negedge clk);
    chk("R1", "cleared reg r6 on store data", dmem_wdata, 16'h0000);
    chk("R1", "cleared reg r5 on store addr", dmem_addr, 16'h0000);
    chk("R6", "store strobe first cycle", {15'b0, dmem_we}, 16'h0001);
    @(negedge clk);
    chk("R2", "advance after store", code_addr, 16'h0002);
    @(negedge clk);
    chk("R4", "advance after set", code_addr, 16'h0004);
    @(negedge clk);
    chk("R5", "add into r14 jumps to 0x0C", code_addr, 16'h000C);
    @(negedge clk);
    chk("R5", "set into r14 jumps to 0", code_addr, 16'h0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule